// File: doc/BRIEF.md
# Bus-to-16-bit Memory Access Splitter

This block sits between a 32-bit system bus request port and a 16-bit external static memory such as NOR flash, PSRAM or SRAM. Each bus request carries a byte address, a write flag, a transfer size, an access mode and write data. The block turns the request into one or two 16-bit memory word accesses. It drives the two active-low byte-lane enables and, for reads, returns one assembled response.

A 32-bit transfer becomes two back-to-back memory accesses, low half first. An 8-bit write uses a single access with only one byte lane enabled. 8-bit and 16-bit reads use a single full-width access. Combinations the memory path cannot serve are refused in one cycle with an error flag and never reach the memory. Refused combinations are unaligned requests, writes in page mode, 8-bit writes in synchronous mode, and reserved codes.

Both sides use a valid/ready handshake. The bus holds `req_valid` and its fields until `req_ready` pulses. The memory side holds `mem_valid` and its fields until the memory answers with `mem_ready`.

Top module: `mem16_splitter`

## Requirements
- R1: During and after reset, until a request arrives, `req_ready`, `rsp_error` and `mem_valid` are low and `mem_be_n` is 2'b11.
- R2: The memory word address is the byte address shifted right by one (`req_addr[26:1]`). A 16-bit request (size code 1) makes exactly one memory access with `mem_be_n` = 2'b00. A 16-bit read returns the word zero-extended in `rsp_rdata`.
- R3: A 32-bit request (size code 2) makes exactly two accesses. The first goes to word address w and the second to w+1. On a write, the first access carries `req_wdata[15:0]` and the second carries `req_wdata[31:16]`. On a read, `rsp_rdata` is {second word, first word}.
- R4: An 8-bit write (size code 0) makes one access, and the byte `req_wdata[7:0]` appears on both halves of `mem_wdata`. When `req_addr[0]` is 0, `mem_be_n` is 2'b10 (bit 0 is the lower lane). When it is 1, `mem_be_n` is 2'b01 (bit 1 is the upper lane).
- R5: An 8-bit read makes one access with `mem_be_n` = 2'b00. The byte picked by `req_addr[0]` (0 = lower, 1 = upper) is returned zero-extended in `rsp_rdata[7:0]`.
- R6: Mode codes are 0 asynchronous, 1 asynchronous page, 2 synchronous and 3 reserved. A request is refused if it uses mode 3, size code 3, a write in mode 1, or an 8-bit write in mode 2. Reads in modes 0 to 2 are served.
- R7: A 16-bit or 32-bit request with `req_addr[0]` = 1 is refused.
- R8: A refused request raises `req_ready` together with `rsp_error` exactly one cycle after it is accepted. It makes no memory access and leaves memory contents unchanged.
- R9: `req_ready` is a single-cycle pulse. For a served request it rises only after the last memory access has completed, with `rsp_error` low. While `mem_valid` waits for `mem_ready`, the address, enables and write data are held stable.
- R10: The memory may hold `mem_ready` low for any number of cycles. Results are the same as with no wait states, and each wait cycle delays `req_ready` by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = reserved |
| req_mode | input | 2 | 0 async, 1 async page, 2 sync, 3 reserved |
| req_addr | input | 27 | Byte address inside the memory |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request complete pulse |
| rsp_error | output | 1 | Request was refused (valid with req_ready) |
| rsp_rdata | output | 32 | Read result (valid with req_ready on a served read) |
| mem_valid | output | 1 | Memory access request |
| mem_write | output | 1 | Memory access is a write |
| mem_addr | output | 26 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_be_n | output | 2 | Active-low byte enables, bit 1 upper, bit 0 lower |
| mem_ready | input | 1 | Memory access complete |
| mem_rdata | input | 16 | Memory read data, valid with mem_ready |

## Verification
The bench checks 32-bit transfers at a word address two bytes into a 32-bit word. A design that derives the second address wrongly or swaps the halves returns the words out of order there. It drives 8-bit writes to both lanes and reads the word back, so an inverted lane select shows up as a corrupted neighbour byte. Each refused combination is sent on its own, followed by a read-back of the target word. An illegal request that leaked to the memory would show as an extra access or a changed word, and a wrong latency would show as a late or early `req_ready`. Wait-state runs catch a design that drops or advances an access before `mem_ready`.

// File: rtl/msp_pkg.sv
package msp_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        MD_ASYNC = 2'd0,
        MD_PAGE  = 2'd1,
        MD_SYNC  = 2'd2,
        MD_RSVD  = 2'd3
    } mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_MEM  = 1'b1
    } st_e;

endpackage

// File: rtl/msp_req_check.sv
module msp_req_check
    import msp_pkg::*;
(
    input  logic       write,
    input  logic [1:0] size,
    input  logic [1:0] mode,
    input  logic       misaligned,
    output logic       refuse
);
    always_comb begin
        refuse = 1'b0;
        if (size == SZ_RSVD)                                 refuse = 1'b1;
        if (mode == MD_RSVD)                                 refuse = 1'b1;
        if (write && mode == MD_PAGE)                        refuse = 1'b1;
        if (write && size == SZ_BYTE && mode == MD_SYNC)     refuse = 1'b1;
        if (size != SZ_BYTE && misaligned)                   refuse = 1'b1;
    end
endmodule

// File: rtl/msp_lane_gen.sv
module msp_lane_gen
    import msp_pkg::*;
#(
    parameter int MEM_DW = 16,
    localparam int LANES  = MEM_DW / 8,
    localparam int LSB_W  = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int BUS_DW = 2 * MEM_DW
) (
    input  logic [1:0]        size,
    input  logic              write,
    input  logic [LSB_W-1:0]  bsel,
    input  logic              hi_phase,
    input  logic [BUS_DW-1:0] wdata,
    output logic [LANES-1:0]  be_n,
    output logic [MEM_DW-1:0] mem_wd
);
    logic byte_wr;
    assign byte_wr = write && (size == SZ_BYTE);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            if (byte_wr) begin
                be_n[g]          = (bsel != LSB_W'(g));
                mem_wd[g*8 +: 8] = wdata[7:0];
            end else begin
                be_n[g]          = 1'b0;
                mem_wd[g*8 +: 8] = hi_phase ? wdata[MEM_DW + g*8 +: 8] : wdata[g*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/msp_rd_pack.sv
module msp_rd_pack
    import msp_pkg::*;
#(
    parameter int MEM_DW = 16,
    localparam int LANES  = MEM_DW / 8,
    localparam int LSB_W  = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int BUS_DW = 2 * MEM_DW
) (
    input  logic [1:0]        size,
    input  logic [LSB_W-1:0]  bsel,
    input  logic [MEM_DW-1:0] lo_word,
    input  logic [MEM_DW-1:0] hi_word,
    output logic [BUS_DW-1:0] rdata
);
    always_comb begin
        case (size)
            SZ_BYTE: rdata = BUS_DW'(lo_word[8*bsel +: 8]);
            SZ_HALF: rdata = BUS_DW'(lo_word);
            default: rdata = {hi_word, lo_word};
        endcase
    end
endmodule

// File: rtl/mem16_splitter.sv
module mem16_splitter
    import msp_pkg::*;
#(
    parameter int MEM_AW = 26,
    parameter int MEM_DW = 16,
    localparam int LANES   = MEM_DW / 8,
    localparam int LSB_W   = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int BYTE_AW = MEM_AW + LSB_W,
    localparam int BUS_DW  = 2 * MEM_DW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [1:0]         req_size,
    input  logic [1:0]         req_mode,
    input  logic [BYTE_AW-1:0] req_addr,
    input  logic [BUS_DW-1:0]  req_wdata,
    output logic               req_ready,
    output logic               rsp_error,
    output logic [BUS_DW-1:0]  rsp_rdata,
    output logic               mem_valid,
    output logic               mem_write,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic [MEM_DW-1:0]  mem_wdata,
    output logic [LANES-1:0]   mem_be_n,
    input  logic               mem_ready,
    input  logic [MEM_DW-1:0]  mem_rdata
);
    typedef struct packed {
        st_e               st;
        logic              write;
        logic [1:0]        size;
        logic [LSB_W-1:0]  bsel;
        logic              hi;
        logic [MEM_AW-1:0] waddr;
        logic [BUS_DW-1:0] wdata;
        logic [MEM_DW-1:0] lo_data;
        logic              mvalid;
        logic              rdy;
        logic              err;
        logic [BUS_DW-1:0] rdata;
    } state_t;

    state_t q, d;

    logic              refuse;
    logic [LANES-1:0]  lane_be_n;
    logic [MEM_DW-1:0] lane_wd;
    logic [BUS_DW-1:0] packed_rd;
    logic [MEM_DW-1:0] lo_sel;

    msp_req_check u_check (
        .write      (req_write),
        .size       (req_size),
        .mode       (req_mode),
        .misaligned (|req_addr[LSB_W-1:0]),
        .refuse     (refuse)
    );

    msp_lane_gen #(.MEM_DW(MEM_DW)) u_lane (
        .size     (q.size),
        .write    (q.write),
        .bsel     (q.bsel),
        .hi_phase (q.hi),
        .wdata    (q.wdata),
        .be_n     (lane_be_n),
        .mem_wd   (lane_wd)
    );

    assign lo_sel = q.hi ? q.lo_data : mem_rdata;

    msp_rd_pack #(.MEM_DW(MEM_DW)) u_pack (
        .size    (q.size),
        .bsel    (q.bsel),
        .lo_word (lo_sel),
        .hi_word (mem_rdata),
        .rdata   (packed_rd)
    );

    always_comb begin
        d     = q;
        d.rdy = 1'b0;
        d.err = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid && !q.rdy) begin
                    if (refuse) begin
                        d.rdy = 1'b1;
                        d.err = 1'b1;
                    end else begin
                        d.st     = ST_MEM;
                        d.mvalid = 1'b1;
                        d.write  = req_write;
                        d.size   = req_size;
                        d.bsel   = req_addr[LSB_W-1:0];
                        d.hi     = 1'b0;
                        d.waddr  = req_addr[LSB_W +: MEM_AW];
                        d.wdata  = req_wdata;
                    end
                end
            end
            default: begin
                if (mem_ready) begin
                    if (q.size == SZ_WORD && !q.hi) begin
                        d.hi      = 1'b1;
                        d.waddr   = q.waddr + 1'b1;
                        d.lo_data = mem_rdata;
                    end else begin
                        d.st     = ST_IDLE;
                        d.mvalid = 1'b0;
                        d.rdy    = 1'b1;
                        if (!q.write) d.rdata = packed_rd;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready = q.rdy;
    assign rsp_error = q.err;
    assign rsp_rdata = q.rdata;
    assign mem_valid = q.mvalid;
    assign mem_write = q.write;
    assign mem_addr  = q.waddr;
    assign mem_wdata = lane_wd;
    assign mem_be_n  = q.mvalid ? lane_be_n : '1;

    // R9: access fields stay put while the memory stalls
    a_r9_hold_access: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                       $stable(mem_be_n) && $stable(mem_wdata)));

    a_r9_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    a_r9_ready_after_mem: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_valid);

    a_r8_error_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mem_valid && !req_ready && refuse) |=> (rsp_error && req_ready && !mem_valid));

    a_r4_some_lane: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_be_n != '1));

    a_r3_next_word: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && q.size == SZ_WORD && !q.hi) |=>
            (mem_valid && mem_addr == MEM_AW'($past(mem_addr) + 1'b1)));

    a_r1_idle_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_valid |-> (mem_be_n == '1));

endmodule

// File: tb/mem16_splitter_tb_top.sv
module mem16_splitter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [1:0]  req_mode = 2'd0;
    logic [26:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_error;
    logic [31:0] rsp_rdata;
    logic        mem_valid, mem_write, mem_ready;
    logic [25:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic [1:0]  mem_be_n;

    always #5 clk = ~clk;

    mem16_splitter dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_mode(req_mode), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be_n(mem_be_n),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    // memory model: 256 words, word i starts as A000+i
    logic [15:0] marr [256];
    int          wait_cfg = 0;
    int          wait_cnt;
    int          acc_cnt;
    logic [25:0] log_ad [1024];
    logic [15:0] log_wd [1024];
    logic [1:0]  log_be [1024];

    assign mem_ready = mem_valid && (wait_cnt == 0);
    assign mem_rdata = marr[mem_addr[7:0]];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) marr[i] <= 16'hA000 + 16'(i);
            acc_cnt  <= 0;
            wait_cnt <= wait_cfg;
        end else if (mem_valid) begin
            if (mem_ready) begin
                if (mem_write) begin
                    if (!mem_be_n[0]) marr[mem_addr[7:0]][7:0]  <= mem_wdata[7:0];
                    if (!mem_be_n[1]) marr[mem_addr[7:0]][15:8] <= mem_wdata[15:8];
                end
                log_ad[acc_cnt[9:0]] <= mem_addr;
                log_wd[acc_cnt[9:0]] <= mem_wdata;
                log_be[acc_cnt[9:0]] <= mem_be_n;
                acc_cnt  <= acc_cnt + 1;
                wait_cnt <= wait_cfg;
            end else begin
                wait_cnt <= wait_cnt - 1;
            end
        end else begin
            wait_cnt <= wait_cfg;
        end
    end

    int checks = 0;
    int errors = 0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_req(input logic wr, input logic [1:0] sz, input logic [1:0] md,
                           input logic [31:0] addr, input logic [31:0] wd,
                           output logic err, output logic [31:0] rd,
                           output int nacc, output int base, output int lat);
        base = acc_cnt;
        req_write = wr; req_size = sz; req_mode = md;
        req_addr = addr[26:0]; req_wdata = wd; req_valid = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!req_ready && lat < 200);
        err  = rsp_error;
        rd   = rsp_rdata;
        req_valid = 1'b0;
        @(negedge clk);
        nacc = acc_cnt - base;
    endtask

    typedef struct packed {
        logic        wr;
        logic [1:0]  sz;
        logic [1:0]  md;
        logic [31:0] addr;
        logic [31:0] wd;
        logic        err;
        logic [1:0]  nacc;
        logic [1:0]  be;
        logic [15:0] wd0;
        logic [31:0] rd;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 2'd2, 2'd0, 32'h08, 32'h0,        1'b0, 2'd2, 2'b00, 16'h0,    32'hA005A004}, // R3 read
        '{1'b0, 2'd1, 2'd0, 32'h06, 32'h0,        1'b0, 2'd1, 2'b00, 16'h0,    32'h0000A003}, // R2
        '{1'b0, 2'd0, 2'd0, 32'h07, 32'h0,        1'b0, 2'd1, 2'b00, 16'h0,    32'h000000A0}, // R5 upper
        '{1'b0, 2'd0, 2'd0, 32'h06, 32'h0,        1'b0, 2'd1, 2'b00, 16'h0,    32'h00000003}, // R5 lower
        '{1'b1, 2'd0, 2'd0, 32'h11, 32'h0000005C, 1'b0, 2'd1, 2'b01, 16'h5C5C, 32'h0},        // R4 upper
        '{1'b1, 2'd0, 2'd0, 32'h10, 32'h00000077, 1'b0, 2'd1, 2'b10, 16'h7777, 32'h0},        // R4 lower
        '{1'b0, 2'd1, 2'd0, 32'h10, 32'h0,        1'b0, 2'd1, 2'b00, 16'h0,    32'h00005C77}, // R4 readback
        '{1'b1, 2'd2, 2'd0, 32'h20, 32'h12345678, 1'b0, 2'd2, 2'b00, 16'h5678, 32'h0},        // R3 write
        '{1'b0, 2'd2, 2'd0, 32'h20, 32'h0,        1'b0, 2'd2, 2'b00, 16'h0,    32'h12345678}, // R3 readback
        '{1'b1, 2'd1, 2'd0, 32'h01, 32'h0000DEAD, 1'b1, 2'd0, 2'b11, 16'h0,    32'h0},        // R7 write
        '{1'b0, 2'd1, 2'd0, 32'h00, 32'h0,        1'b0, 2'd1, 2'b00, 16'h0,    32'h0000A000}, // R8 untouched
        '{1'b0, 2'd2, 2'd0, 32'h03, 32'h0,        1'b1, 2'd0, 2'b11, 16'h0,    32'h0},        // R7 read32
        '{1'b0, 2'd2, 2'd0, 32'h02, 32'h0,        1'b0, 2'd2, 2'b00, 16'h0,    32'hA002A001}, // R3 offset 2
        '{1'b0, 2'd3, 2'd0, 32'h00, 32'h0,        1'b1, 2'd0, 2'b11, 16'h0,    32'h0},        // R6 size3
        '{1'b1, 2'd1, 2'd1, 32'h30, 32'h00001111, 1'b1, 2'd0, 2'b11, 16'h0,    32'h0},        // R6 page write
        '{1'b1, 2'd0, 2'd2, 32'h30, 32'h00000099, 1'b1, 2'd0, 2'b11, 16'h0,    32'h0},        // R6 sync byte write
        '{1'b0, 2'd1, 2'd3, 32'h30, 32'h0,        1'b1, 2'd0, 2'b11, 16'h0,    32'h0},        // R6 mode3
        '{1'b0, 2'd0, 2'd2, 32'h07, 32'h0,        1'b0, 2'd1, 2'b00, 16'h0,    32'h000000A0}, // R6 sync byte read
        '{1'b0, 2'd1, 2'd1, 32'h30, 32'h0,        1'b0, 2'd1, 2'b00, 16'h0,    32'h0000A018}, // R6 page read, R8
        '{1'b1, 2'd1, 2'd2, 32'h30, 32'h0000BEEF, 1'b0, 2'd1, 2'b00, 16'hBEEF, 32'h0},        // R2 sync write
        '{1'b0, 2'd1, 2'd1, 32'h30, 32'h0,        1'b0, 2'd1, 2'b00, 16'h0,    32'h0000BEEF}, // R2 readback
        '{1'b0, 2'd1, 2'd0, 32'h31, 32'h0,        1'b1, 2'd0, 2'b11, 16'h0,    32'h0},        // R7 read16
        '{1'b0, 2'd2, 2'd1, 32'h30, 32'h0,        1'b0, 2'd2, 2'b00, 16'h0,    32'hA019BEEF}  // R3 page read32
    };

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual=hang expected=completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic        e;
        logic [31:0] r;
        int          n, b, l;

        repeat (4) @(negedge clk);
        check("R1", "req_ready in reset", 32'(req_ready), 32'd0);
        check("R1", "mem_valid in reset", 32'(mem_valid), 32'd0);
        check("R1", "mem_be_n in reset",  32'(mem_be_n),  32'h3);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", "rsp_error after reset", 32'(rsp_error), 32'd0);
        check("R1", "req_ready after reset", 32'(req_ready), 32'd0);

        for (int k = 0; k < NV; k++) begin
            vec_t v;
            v = VEC[k];
            run_req(v.wr, v.sz, v.md, v.addr, v.wd, e, r, n, b, l);
            check(v.err ? "R8" : "R9", $sformatf("vec%0d error flag", k), 32'(e), 32'(v.err));
            check(v.err ? "R8" : "R3", $sformatf("vec%0d access count", k), 32'(n), 32'(v.nacc));
            check("R9", $sformatf("vec%0d latency", k), 32'(l),
                  v.err ? 32'd1 : 32'(v.nacc) + 32'd1);
            if (!v.err) begin
                check("R2", $sformatf("vec%0d word address", k),
                      32'(log_ad[b[9:0]]), 32'(v.addr[26:1]));
                check(v.wr ? "R4" : "R5", $sformatf("vec%0d byte enables", k),
                      32'(log_be[b[9:0]]), 32'(v.be));
                if (v.wr)
                    check("R4", $sformatf("vec%0d first write data", k),
                          32'(log_wd[b[9:0]]), 32'(v.wd0));
                else
                    check("R5", $sformatf("vec%0d read data", k), r, v.rd);
                if (v.nacc == 2'd2) begin
                    check("R3", $sformatf("vec%0d second address", k),
                          32'(log_ad[b[9:0] + 10'd1]), 32'(v.addr[26:1]) + 32'd1);
                    if (v.wr)
                        check("R3", $sformatf("vec%0d second write data", k),
                              32'(log_wd[b[9:0] + 10'd1]), 32'(v.wd[31:16]));
                end
            end
        end

        // R10: wait states
        wait_cfg = 3;
        @(negedge clk);
        run_req(1'b0, 2'd2, 2'd0, 32'h20, 32'h0, e, r, n, b, l);
        check("R10", "stalled read32 data", r, 32'h12345678);
        check("R10", "stalled read32 accesses", 32'(n), 32'd2);
        check("R10", "stalled read32 latency", 32'(l), 32'd9);
        wait_cfg = 2;
        @(negedge clk);
        run_req(1'b1, 2'd0, 2'd0, 32'h21, 32'h000000AB, e, r, n, b, l);
        check("R10", "stalled byte write latency", 32'(l), 32'd4);
        check("R10", "stalled byte write lanes", 32'(log_be[b[9:0]]), 32'h1);
        wait_cfg = 0;
        @(negedge clk);
        run_req(1'b0, 2'd1, 2'd0, 32'h20, 32'h0, e, r, n, b, l);
        check("R4", "lane merge after stalled write", r, 32'h0000AB78);

        // R8: refused request leaves the target untouched
        run_req(1'b1, 2'd2, 2'd1, 32'h20, 32'hFFFFFFFF, e, r, n, b, l);
        check("R8", "page write32 refused", 32'(e), 32'd1);
        run_req(1'b0, 2'd2, 2'd0, 32'h20, 32'h0, e, r, n, b, l);
        check("R8", "word after refused write", r, 32'h1234AB78);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule